// File: doc/BRIEF.md
# Host-Controller Command Mailbox Registers

This block is a byte mailbox between a host-side byte link and the I/O port of an 8-bit embedded controller. The host writes command characters one at a time into a receive register. The controller collects each one through its port. A full flag in the controller's status register shows that an unread character is waiting. The host has no matching flag. It relies on the controller keeping pace with the incoming characters.

For replies, the controller writes one character at a time into a transmit register. It also writes a response-active byte, 0x01 while a reply is in progress and 0x00 once the reply is done. The host polls that byte and, while it is 0x01, reads characters until a carriage return (0x0D). A transmit-pending status bit sets when the controller writes a character and clears when the host reads it. The controller uses this bit to decide when to place the next character.

On the controller side, reads are combinational from `ctl_addr`. Side effects take place on the clock edge at which `ctl_rd` or `ctl_wr` is high. The host side uses a one-bit select: 0 selects the response character and 1 selects the response-active byte.

Top module: `cmd_mailbox_regs`

## Requirements
- R1: After reset, the receive-full, overrun and transmit-pending bits are 0, and the response-active byte reads 0x00 from both sides.
- R2: A host write captures `host_wdata`. From the next cycle, controller address 0x60 returns that byte and bit 0 (receive-full) of status address 0xFC is 1.
- R3: A controller read of 0x60 clears receive-full on that edge. If a host write happens in the same cycle, receive-full stays set and the new byte is held.
- R4: A host write while receive-full is set, and not cleared by a read of 0x60 in the same cycle, replaces the byte and sets the sticky overrun bit 1 of 0xFC. A controller read of 0xFC clears only the overrun bit. If a new overrun occurs in that same cycle, the bit stays set.
- R5: A controller write to 0x61 stores the byte and sets bit 4 (transmit-pending) of 0xFC. The byte is visible at `host_rdata` with `host_addr`=0 and at controller address 0x61.
- R6: A host read with `host_addr`=0 clears transmit-pending. A controller write to 0x61 in the same cycle leaves transmit-pending set.
- R7: A controller write to 0x62 stores the response-active byte. It reads back from controller address 0x62 and from `host_rdata` with `host_addr`=1. A host read with `host_addr`=1 changes no state.
- R8: Bits 7:5 and 3:2 of 0xFC read 0, and every other controller address reads 0x00. Writes to addresses other than 0x61 and 0x62 change no state. Reads of addresses other than 0x60 and 0xFC change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_addr | input | 8 | Controller port sub-address |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_rd | input | 1 | Controller read strobe (side effects only) |
| ctl_wdata | input | 8 | Controller write data |
| ctl_rdata | output | 8 | Controller read data for `ctl_addr` |
| host_wr | input | 1 | Host command-byte write strobe |
| host_wdata | input | 8 | Host command byte |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host select: 0 response byte, 1 response-active byte |
| host_rdata | output | 8 | Host read data |

## Verification
The hardest cases to reach are the same-cycle collisions. These are a host write against a controller read of 0x60, a host read against a controller write of 0x61, and a new overrun against a status read that clears it. Each needs both sides to strobe on the same edge, which a normal command-and-reply exchange never does. The bench drives those collisions as directed steps. It then runs a long stretch of random stimulus that biases addresses toward the mapped registers, so that collisions recur in many state combinations. A behavioural reference model is compared with both read ports on every cycle.

// File: rtl/cmd_mailbox_regs.sv
module cmd_mailbox_regs #(
  parameter logic [7:0] A_RX   = 8'h60,
  parameter logic [7:0] A_TX   = 8'h61,
  parameter logic [7:0] A_ACT  = 8'h62,
  parameter logic [7:0] A_STAT = 8'hFC,
  parameter int STAT_RX_BIT  = 0,
  parameter int STAT_OVR_BIT = 1,
  parameter int STAT_TX_BIT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctl_addr,
  input  logic       ctl_wr,
  input  logic       ctl_rd,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  input  logic       host_addr,
  output logic [7:0] host_rdata
);

  logic [7:0] rx_q, tx_q, act_q;
  logic       rx_full, ovr, tx_pend;
  logic [7:0] stat;

  wire rd_rx    = ctl_rd && (ctl_addr == A_RX);
  wire rd_stat  = ctl_rd && (ctl_addr == A_STAT);
  wire wr_tx    = ctl_wr && (ctl_addr == A_TX);
  wire wr_act   = ctl_wr && (ctl_addr == A_ACT);
  wire host_take = host_rd && !host_addr;
  wire ovr_hit  = host_wr && rx_full && !rd_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      tx_q    <= '0;
      act_q   <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      tx_pend <= 1'b0;
    end else begin
      if (host_wr) rx_q <= host_wdata;
      if (wr_tx)   tx_q <= ctl_wdata;
      if (wr_act)  act_q <= ctl_wdata;

      if (host_wr)    rx_full <= 1'b1;
      else if (rd_rx) rx_full <= 1'b0;

      if (ovr_hit)      ovr <= 1'b1;
      else if (rd_stat) ovr <= 1'b0;

      if (wr_tx)          tx_pend <= 1'b1;
      else if (host_take) tx_pend <= 1'b0;
    end
  end

  always_comb begin
    stat = '0;
    stat[STAT_RX_BIT]  = rx_full;
    stat[STAT_OVR_BIT] = ovr;
    stat[STAT_TX_BIT]  = tx_pend;
  end

  always_comb begin
    unique case (ctl_addr)
      A_RX:    ctl_rdata = rx_q;
      A_TX:    ctl_rdata = tx_q;
      A_ACT:   ctl_rdata = act_q;
      A_STAT:  ctl_rdata = stat;
      default: ctl_rdata = '0;
    endcase
  end

  assign host_rdata = host_addr ? act_q : tx_q;

endmodule

// File: rtl/cmd_mailbox_regs_chk.sv
module cmd_mailbox_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_addr,
  input logic       ctl_wr,
  input logic       ctl_rd,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_addr,
  input logic [7:0] host_rdata,
  input logic       rx_full,
  input logic       ovr,
  input logic       tx_pend
);

  AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> rx_full); // R2

  AST_RX_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && ctl_addr == 8'h60 && !host_wr) |=> !rx_full); // R3

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && rx_full && !(ctl_rd && ctl_addr == 8'h60)) |=> ovr); // R4

  AST_TX_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_addr == 8'h61) |=> tx_pend); // R5

  AST_TX_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_addr && !(ctl_wr && ctl_addr == 8'h61)) |=> !tx_pend); // R6

  AST_ACT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_addr == 8'h62) |=> (ctl_addr != 8'h62 || ctl_rdata == $past(ctl_wdata))); // R7

  AST_STAT_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_addr == 8'hFC) |-> (ctl_rdata[7:5] == 3'b0 && ctl_rdata[3:2] == 2'b0)); // R8

  AST_HOST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr && !(ctl_wr && ctl_addr == 8'h62)) |=> (!host_addr || $stable(host_rdata))); // R7

endmodule

bind cmd_mailbox_regs cmd_mailbox_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_rdata(host_rdata), .rx_full(rx_full), .ovr(ovr),
  .tx_pend(tx_pend)
);

// File: tb/cmd_mailbox_regs_tb.sv
module cmd_mailbox_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctl_addr = '0, ctl_wdata = '0, host_wdata = '0;
  logic       ctl_wr = 1'b0, ctl_rd = 1'b0, host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0] ctl_rdata, host_rdata;

  int vectors = 0;
  int errors  = 0;

  int m_rx, m_tx, m_act, m_full, m_ovr, m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_mailbox_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata)
  );

  function automatic int exp_ctl(input int a);
    case (a)
      8'h60:   return m_rx;
      8'h61:   return m_tx;
      8'h62:   return m_act;
      8'hFC:   return (m_pend << 4) | (m_ovr << 1) | m_full;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic model_reset();
    m_rx = 0; m_tx = 0; m_act = 0; m_full = 0; m_ovr = 0; m_pend = 0;
  endtask

  task automatic model_clock();
    bit rd60, rdfc, w61, w62, take, hit;
    rd60 = ctl_rd && ctl_addr == 8'h60;
    rdfc = ctl_rd && ctl_addr == 8'hFC;
    w61  = ctl_wr && ctl_addr == 8'h61;
    w62  = ctl_wr && ctl_addr == 8'h62;
    take = host_rd && !host_addr;
    hit  = host_wr && m_full == 1 && !rd60;
    if (host_wr) m_rx = host_wdata;
    if (w61) m_tx = ctl_wdata;
    if (w62) m_act = ctl_wdata;
    m_full = host_wr ? 1 : (rd60 ? 0 : m_full);
    m_ovr  = hit ? 1 : (rdfc ? 0 : m_ovr);
    m_pend = w61 ? 1 : (take ? 0 : m_pend);
  endtask

  task automatic step(input string tag, input logic [7:0] ca, input bit cw, input bit cr,
                      input logic [7:0] cd, input bit hw, input logic [7:0] hd,
                      input bit hr, input bit ha);
    @(negedge clk);
    ctl_addr = ca; ctl_wr = cw; ctl_rd = cr; ctl_wdata = cd;
    host_wr = hw; host_wdata = hd; host_rd = hr; host_addr = ha;
    #1;
    check(tag, ctl_rdata, exp_ctl(ca), "ctl_rdata");
    check(tag, host_rdata, ha ? m_act : m_tx, "host_rdata");
    @(posedge clk);
    model_clock();
  endtask

  task automatic idle(input string tag, input logic [7:0] ca, input bit ha);
    step(tag, ca, 0, 0, 8'h00, 0, 8'h00, 0, ha);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    idle("R1", 8'hFC, 0);
    idle("R1", 8'h62, 1);
    check("R1", ctl_rdata, 8'h00, "reset status");

    // R2: host writes command byte
    step("R2", 8'hFC, 0, 0, 8'h00, 1, 8'h47, 0, 0);
    idle("R2", 8'h60, 0);
    check("R2", ctl_rdata, 8'h47, "rx byte");
    idle("R2", 8'hFC, 0);
    // R3: read 0x60 clears full; collision keeps it set
    step("R3", 8'h60, 0, 1, 8'h00, 0, 8'h00, 0, 0);
    idle("R3", 8'hFC, 0);
    step("R3", 8'h60, 0, 1, 8'h00, 1, 8'h45, 0, 0);
    idle("R3", 8'hFC, 0);
    check("R3", ctl_rdata, 8'h01, "full after collision");
    // R4: overrun, clear by status read, collision with new overrun
    step("R4", 8'h00, 0, 0, 8'h00, 1, 8'h54, 0, 0);
    idle("R4", 8'hFC, 0);
    check("R4", ctl_rdata, 8'h03, "overrun set");
    step("R4", 8'hFC, 0, 1, 8'h00, 0, 8'h00, 0, 0);
    idle("R4", 8'hFC, 0);
    check("R4", ctl_rdata, 8'h01, "overrun cleared only");
    step("R4", 8'hFC, 0, 1, 8'h00, 1, 8'h0D, 0, 0);
    idle("R4", 8'hFC, 0);
    check("R4", ctl_rdata, 8'h03, "overrun kept on collision");
    idle("R4", 8'h60, 0);
    // R5/R6/R7: response stream "OK\r"
    step("R7", 8'h62, 1, 0, 8'h01, 0, 8'h00, 0, 1);
    idle("R7", 8'h62, 1);
    check("R7", host_rdata, 8'h01, "active byte");
    step("R5", 8'h61, 1, 0, 8'h4F, 0, 8'h00, 0, 0);
    idle("R5", 8'hFC, 0);
    step("R6", 8'hFC, 0, 0, 8'h00, 0, 8'h00, 1, 0);
    idle("R6", 8'hFC, 0);
    step("R6", 8'h61, 1, 0, 8'h4B, 0, 8'h00, 1, 0);
    idle("R6", 8'hFC, 0);
    check("R6", ctl_rdata[4], 1'b1, "pending kept on collision");
    step("R6", 8'h61, 1, 0, 8'h0D, 0, 8'h00, 1, 0);
    step("R6", 8'h61, 0, 0, 8'h00, 0, 8'h00, 1, 0);
    check("R6", host_rdata, 8'h0D, "carriage return");
    idle("R6", 8'hFC, 0);
    step("R7", 8'h62, 1, 0, 8'h00, 0, 8'h00, 1, 1);
    idle("R7", 8'h62, 1);
    // R8: unmapped accesses
    step("R8", 8'h63, 1, 1, 8'hFF, 0, 8'h00, 0, 0);
    step("R8", 8'hFC, 1, 0, 8'hFF, 0, 8'h00, 0, 0);
    idle("R8", 8'hFC, 0);
    idle("R8", 8'hA5, 1);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int sel = $urandom_range(0, 4);
      string tag;
      case (sel)
        0: begin a = 8'h60; tag = "R3"; end
        1: begin a = 8'h61; tag = "R5"; end
        2: begin a = 8'h62; tag = "R7"; end
        3: begin a = 8'hFC; tag = "R4"; end
        default: begin a = 8'($urandom); tag = "R8"; end
      endcase
      step(tag, a, 1'($urandom_range(0, 3) == 0), 1'($urandom), 8'($urandom),
           1'($urandom_range(0, 2) == 0), 8'($urandom), 1'($urandom), 1'($urandom));
    end
    summary();
  end
endmodule